// File: doc/BRIEF.md
# Magic Divisor Constant Generator

This block turns an unsigned divisor into the three constants that a multiply-and-shift divider needs to replace a true division. It returns a post-shift, a multiplier and a round-down correction flag. The shift is always the position of the divisor's leading one, so no search over candidate shifts takes place. A long division of a power of two by the divisor gives the quotient and remainder from which the multiplier and the correction flag are chosen. The multiplier is returned with its top bit cleared, because the consuming datapath treats that bit as always set.

A caller raises `start_i` for one cycle with the divisor on `divisor_i`. The block then shows `busy_o` while an internal restoring divider produces one quotient bit per cycle, and pulses `done_o` once the outputs are valid. Power-of-two divisors are marked on `pow2_o`, so the caller can use a plain shift instead. A zero divisor is rejected at once through `err_o`.

Top module: `magdiv_gen`

## Requirements
- R1: For a nonzero divisor d, `shift_o` equals floor(log2 d), the bit index of the highest set bit of d.
- R2: Let N = 2^(shift+DW), m = ceil(N/d) and e = N mod d. When e <= 2^shift, `rdown_o` is 1 and the multiplier value is m-1.
- R3: When e > 2^shift, `rdown_o` is 0 and the multiplier value is m.
- R4: `mult_o` carries the low DW bits of the chosen multiplier value with bit DW-1 forced to 0.
- R5: `pow2_o` is 1 exactly when d is a power of two. In that case `rdown_o` is 1 and `mult_o` is 2^(DW-1)-1.
- R6: A start is accepted only while `busy_o` is 0. For a nonzero divisor, `busy_o` is 1 from the cycle after acceptance until `done_o` rises. `done_o` is high for one cycle, after the (2*DW+2)th rising edge, counting the accepting edge as the first.
- R7: A start pulse while `busy_o` is 1 is ignored. The running computation completes with the original divisor and its original timing.
- R8: A zero divisor raises `done_o` and `err_o` after the accepting edge alone. `shift_o`, `mult_o`, `rdown_o` and `pow2_o` are all 0. The next successful completion clears `err_o`.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `rdown_o`, `pow2_o`, `shift_o` and `mult_o` are all 0.
- R10: `shift_o`, `mult_o`, `rdown_o`, `pow2_o` and `err_o` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to compute constants for `divisor_i` |
| divisor_i | input | DW | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when the outputs are updated |
| err_o | output | 1 | Last request had a zero divisor |
| shift_o | output | $clog2(DW) | Post-shift, floor(log2 d) |
| mult_o | output | DW | Multiplier with its top bit cleared |
| rdown_o | output | 1 | Round-down correction required |
| pow2_o | output | 1 | Divisor is a power of two |

## Verification
The quotient register shifts one bit per cycle and its count decides when the run ends. A wrong count or a lost dividend bit appears at the first `done_o` as a wrong multiplier, or as a pulse earlier or later than 2*DW+2 edges. A wrong remainder shows up as a flipped `rdown_o`, or as a multiplier off by one, on the same completion. A divisor or shift captured incorrectly at the start gives a `shift_o` whose shifted divisor is not 1, which the checker catches in the cycle of completion. A stray start during a run shows up as a changed result or changed latency for that run.

// File: rtl/magdiv_pkg.sv
package magdiv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } magdiv_state_e;

  // Index of the highest set bit; 0 for a zero input.
  function automatic int top_one_index(input logic [63:0] v);
    int idx;
    idx = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Exactly one bit set.
  function automatic logic single_bit(input logic [63:0] v);
    return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction

endpackage

// File: rtl/magdiv_lod.sv
// Leading-one detector: shift constant (R1) and power-of-two flag (R5).
module magdiv_lod #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic [DW-1:0] val_i,
  output logic [SW-1:0] idx_o,
  output logic          pow2_o,
  output logic          zero_o
);
  always_comb begin
    idx_o  = SW'(magdiv_pkg::top_one_index(64'(val_i)));
    pow2_o = magdiv_pkg::single_bit(64'(val_i));
    zero_o = (val_i == '0);
  end
endmodule

// File: rtl/magdiv_rdiv.sv
// Iterative restoring divider, one quotient bit per cycle.
module magdiv_rdiv #(
  parameter int DW = 32,
  parameter int NW = 2 * DW,
  parameter int QW = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [NW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic [QW-1:0] quot_o,
  output logic [DW-1:0] rem_o,
  output logic          fin_o
);
  localparam int CW = $clog2(NW);

  logic [NW-1:0] quo_q;
  logic [DW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fin_q;

  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          qbit;

  always_comb begin
    trial = {rem_q, quo_q[NW-1]};
    if (trial >= {1'b0, divisor_i}) begin
      diff = trial - {1'b0, divisor_i};
      qbit = 1'b1;
    end else begin
      diff = trial;
      qbit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        quo_q <= dividend_i;
        rem_q <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        quo_q <= {quo_q[NW-2:0], qbit};
        rem_q <= DW'(diff);
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(NW - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quot_o = QW'(quo_q);
  assign rem_o  = rem_q;
  assign fin_o  = fin_q;
endmodule

// File: rtl/magdiv_pick.sv
// Ceiling, round-down decision and top-bit clearing (R2, R3, R4).
module magdiv_pick #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW),
  parameter int QW = DW + 2
) (
  input  logic [QW-1:0] quot_i,
  input  logic [DW-1:0] rem_i,
  input  logic [SW-1:0] shift_i,
  output logic [DW-1:0] mult_o,
  output logic          rdown_o
);
  logic [QW-1:0] ceil_m;
  logic [QW-1:0] chosen;
  logic [DW:0]   limit;

  always_comb begin
    ceil_m  = quot_i + QW'(rem_i != '0);
    limit   = (DW+1)'(1) << shift_i;
    rdown_o = ({1'b0, rem_i} <= limit);
    chosen  = rdown_o ? (ceil_m - QW'(1)) : ceil_m;
    mult_o  = DW'(chosen) & {1'b0, {(DW-1){1'b1}}};
  end
endmodule

// File: rtl/magdiv_gen.sv
module magdiv_gen #(
  parameter int  DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [SW-1:0] shift_o,
  output logic [DW-1:0] mult_o,
  output logic          rdown_o,
  output logic          pow2_o
);
  import magdiv_pkg::*;

  localparam int NW = 2 * DW;
  localparam int QW = DW + 2;

  magdiv_state_e state_q;
  logic [DW-1:0] d_q;
  logic [SW-1:0] shift_q;
  logic          pow2_q;

  // Named events for the checker.
  logic          start_take;
  logic          start_drop;
  logic          div_fin;

  logic [SW-1:0] lod_idx;
  logic          lod_pow2;
  logic          lod_zero;
  logic [NW-1:0] dividend;
  logic [QW-1:0] div_quot;
  logic [DW-1:0] div_rem;
  logic [DW-1:0] sel_mult;
  logic          sel_rdown;

  assign start_take = start_i && (state_q == ST_IDLE);
  assign start_drop = start_i && (state_q != ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);

  magdiv_lod #(.DW(DW), .SW(SW)) u_lod (
    .val_i  (divisor_i),
    .idx_o  (lod_idx),
    .pow2_o (lod_pow2),
    .zero_o (lod_zero)
  );

  assign dividend = {{(NW-1){1'b0}}, 1'b1} << (DW + int'(lod_idx));

  magdiv_rdiv #(.DW(DW), .NW(NW), .QW(QW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_take && !lod_zero),
    .dividend_i (dividend),
    .divisor_i  (d_q),
    .quot_o     (div_quot),
    .rem_o      (div_rem),
    .fin_o      (div_fin)
  );

  magdiv_pick #(.DW(DW), .SW(SW), .QW(QW)) u_pick (
    .quot_i  (div_quot),
    .rem_i   (div_rem),
    .shift_i (shift_q),
    .mult_o  (sel_mult),
    .rdown_o (sel_rdown)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      d_q     <= '0;
      shift_q <= '0;
      pow2_q  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      shift_o <= '0;
      mult_o  <= '0;
      rdown_o <= 1'b0;
      pow2_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            if (lod_zero) begin
              // R8: reject a zero divisor at once
              done_o  <= 1'b1;
              err_o   <= 1'b1;
              shift_o <= '0;
              mult_o  <= '0;
              rdown_o <= 1'b0;
              pow2_o  <= 1'b0;
            end else begin
              state_q <= ST_RUN;
              d_q     <= divisor_i;
              shift_q <= lod_idx;
              pow2_q  <= lod_pow2;
            end
          end
        end
        default: begin
          if (div_fin) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            err_o   <= 1'b0;
            shift_o <= shift_q;
            mult_o  <= sel_mult;
            rdown_o <= sel_rdown;
            pow2_o  <= pow2_q;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/magdiv_gen_chk.sv
module magdiv_gen_chk #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [SW-1:0] shift_o,
  input logic [DW-1:0] mult_o,
  input logic          rdown_o,
  input logic          pow2_o,
  input logic [DW-1:0] d_q,
  input logic          start_drop
);
  p_shift_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> ((d_q >> shift_o) == DW'(1)));

  p_msb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mult_o[DW-1]);

  p_pow2_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pow2_o) |-> (rdown_o && (mult_o == {1'b0, {(DW-1){1'b1}}})));

  p_busy_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> $past(busy_o));

  p_drop_keeps_d_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> $stable(d_q));

  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (mult_o == '0 && shift_o == '0 && !rdown_o && !pow2_o));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mult_o) || !$stable(shift_o) || !$stable(err_o)) |-> done_o);
endmodule

bind magdiv_gen magdiv_gen_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .shift_o    (shift_o),
  .mult_o     (mult_o),
  .rdown_o    (rdown_o),
  .pow2_o     (pow2_o),
  .d_q        (d_q),
  .start_drop (start_drop)
);

// File: tb/magdiv_gen_bench.sv
module magdiv_gen_bench;
  localparam int BW = 10;
  localparam int SWB = $clog2(BW);
  localparam int LAT = 2 * BW + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [BW-1:0]  divisor = '0;
  logic           busy, done, err, rdown, pow2;
  logic [SWB-1:0] shift;
  logic [BW-1:0]  mult;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  magdiv_gen #(.DW(BW)) u_magdiv_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .divisor_i(divisor),
    .busy_o(busy), .done_o(done), .err_o(err), .shift_o(shift),
    .mult_o(mult), .rdown_o(rdown), .pow2_o(pow2)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference constants, computed by integer arithmetic.
  task automatic ref_calc(input int d, output int s, output longint m_out,
                          output int rd, output int p2);
    longint unsigned num, q, e, m;
    s = 0;
    for (int i = 0; i < BW; i++) if (((d >> i) & 1) == 1) s = i;
    num = 64'd1 << (s + BW);
    q = num / longint'(d);
    e = num % longint'(d);
    m = q + ((e != 0) ? 1 : 0);
    if (e <= (64'd1 << s)) begin m = m - 1; rd = 1; end
    else rd = 0;
    m_out = longint'(m % (64'd1 << (BW - 1)));
    p2 = ((d & (d - 1)) == 0) ? 1 : 0;
  endtask

  task automatic launch(input int d, output int lat);
    @(negedge clk);
    divisor = BW'(d);
    start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end while (!done && lat < 1000);
  endtask

  task automatic check_result(input int d, input int lat);
    int s, rd, p2;
    longint m;
    ref_calc(d, s, m, rd, p2);
    chk("R1 shift", shift, s);
    if (rd == 1) chk("R2 mult", mult, m); else chk("R3 mult", mult, m);
    chk(rd == 1 ? "R2 rdown" : "R3 rdown", rdown, rd);
    chk("R4 msb", mult[BW-1], 0);
    chk("R5 pow2", pow2, p2);
    chk("R6 latency", lat, LAT);
    chk("R8 err clear", err, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    int s0, rd0, p20;
    longint m0;
    logic [BW-1:0] hm;
    logic [SWB-1:0] hs;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 err", err, 0);
    chk("R9 mult", mult, 0);
    chk("R9 shift", shift, 0);
    chk("R9 rdown", rdown, 0);
    chk("R9 pow2", pow2, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R6: exhaustive sweep
    for (int d = 1; d < (1 << BW); d++) begin
      launch(d, lat);
      check_result(d, lat);
      @(negedge clk);
      chk("R6 done pulse", done, 0);
    end

    // R10: outputs hold after completion
    hm = mult; hs = shift;
    repeat (5) @(negedge clk);
    chk("R10 mult hold", mult, hm);
    chk("R10 shift hold", shift, hs);

    // R8: zero divisor
    launch(0, lat);
    chk("R8 latency", lat, 1);
    chk("R8 err", err, 1);
    chk("R8 mult", mult, 0);
    chk("R8 shift", shift, 0);
    chk("R8 rdown", rdown, 0);
    chk("R8 pow2", pow2, 0);
    repeat (3) @(negedge clk);
    chk("R10 err hold", err, 1);

    // R7: start during a run is ignored
    @(negedge clk);
    divisor = BW'(7);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (4) begin @(posedge clk); lat++; @(negedge clk); end
    chk("R6 busy during run", busy, 1);
    divisor = BW'(3);
    start = 1'b1;
    @(posedge clk); lat++; @(negedge clk);
    start = 1'b0;
    while (!done && lat < 1000) begin @(posedge clk); lat++; @(negedge clk); end
    ref_calc(7, s0, m0, rd0, p20);
    chk("R7 latency", lat, LAT);
    chk("R7 mult", mult, m0);
    chk("R7 shift", shift, s0);
    chk("R7 rdown", rdown, rd0);
    chk("R8 err cleared", err, 0);

    // Largest and smallest divisors once more
    launch((1 << BW) - 1, lat);
    check_result((1 << BW) - 1, lat);
    launch(1, lat);
    check_result(1, lat);

    finish_run();
  end
endmodule